// File: doc/BRIEF.md
# NMI Edge Detect and Pending Control

This block takes the asynchronous non-maskable interrupt pin of a core and turns it into a one-cycle NMI request. The pin passes through a synchroniser and a pulse-width filter, so glitches shorter than a set number of clocks are rejected. An edge detector then fires only on the edge polarity that an 8-bit mode register selects. Software can write that register as a whole byte or one bit at a time.

When the request fires, an in-progress flag is set. It is shown as bit 7 of a status byte. While the flag is set, every other interrupt and exception request passing through the block is forced to zero. Further NMI edges are dropped while the flag is set; they are not queued. A one-cycle return pulse from the core clears the flag.

Top module: `nmi_edge_ctrl`

## Requirements
- R1: After reset the mode byte reads 0x00, the status byte is 0x00, `nmi_req` is 0 and `req_out` equals `req_in`.
- R2: With mode bit 0 at 0 (the reset value), a filtered high-to-low pin transition raises `nmi_req`, and a low-to-high transition does not.
- R3: With mode bit 0 at 1, a filtered low-to-high transition raises `nmi_req`, and a high-to-low transition does not.
- R4: A byte write (`reg_wr`=1, `reg_bitop`=0) stores `reg_wdata[0]` in mode bit 0. `reg_rdata[7:1]` always reads 0.
- R5: A bit write (`reg_wr`=1, `reg_bitop`=1) sets mode bit 0 to `reg_wdata[0]` only when `reg_bitpos` is 0. A bit write at any other position leaves the mode byte unchanged.
- R6: A pin level that holds for fewer than FILT_CYC consecutive clocks produces no request.
- R7: A valid pin transition that stays stable raises `nmi_req` for exactly one cycle. The request is seen FILT_CYC+2 rising clock edges after the pin changes.
- R8: The cycle after `nmi_req` is 1, status bit 7 reads 1.
- R9: While status bit 7 is 1, valid edges raise no request. They are not replayed after the flag clears.
- R10: While status bit 7 is 1, `req_out` is all zeros. Otherwise `req_out` equals `req_in`.
- R11: A one-cycle `nmi_return` clears status bit 7 on the next edge. If a request fires in the same cycle, the set wins.
- R12: A write to mode bit 0 raises no request in its own cycle, even if the polarity changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous NMI pin level |
| reg_wr | input | 1 | Register write strobe |
| reg_bitop | input | 1 | 1 = single-bit write, 0 = byte write |
| reg_bitpos | input | 3 | Bit index for a single-bit write |
| reg_wdata | input | 8 | Write data; bit 0 is the value for a bit write |
| reg_rdata | output | 8 | Mode byte read-back |
| nmi_return | input | 1 | One-cycle return-from-NMI pulse |
| nmi_req | output | 1 | One-cycle NMI request to the core |
| stat_byte | output | 8 | Status byte; bit 7 is the NMI-in-progress flag |
| req_in | input | REQ_W | Other interrupt and exception requests |
| req_out | output | REQ_W | Requests after masking by the in-progress flag |

## Verification
The pin is driven with clean rising and falling steps under both polarity settings, which confirms that only the selected direction counts. Pulses one clock shorter than the filter window are contrasted with longer ones, which fixes the rejection threshold. A second valid edge sent while the in-progress flag is set, followed by a return pulse and a quiet period, separates dropping an edge from queuing it. Byte and bit writes, including a bit write at a non-zero position, and a polarity flip while the pin is idle, confirm that register traffic alone never makes a request.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_pol_e;

  localparam int MODE_W       = 8;
  localparam int STAT_PEND_IX = 7;

  // True when the filtered level moved in the selected direction.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input edge_pol_e pol);
    return (cur != prev) && (cur == logic'(pol));
  endfunction

  // True when the disagreement counter has seen lim consecutive cycles.
  function automatic logic filt_done(input logic [31:0] cnt,
                                     input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction
endpackage

// File: rtl/nmi_sync_filter.sv
module nmi_sync_filter #(
  parameter int FILT_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic filt_lvl
);
  import nmi_pkg::*;
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sh;
  logic                   sync_lvl;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-2:0], pin};
  end
  assign sync_lvl = sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_lvl <= 1'b0;
      cnt      <= '0;
    end else if (sync_lvl == filt_lvl) begin
      cnt <= '0;
    end else if (filt_done(32'(cnt), 32'(FILT_CYC))) begin
      filt_lvl <= sync_lvl;
      cnt      <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nmi_mode_reg.sv
module nmi_mode_reg
  import nmi_pkg::*;
#(
  parameter int BW = $clog2(MODE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          bitop,
  input  logic [BW-1:0] bitpos,
  input  logic [MODE_W-1:0] wdata,
  output edge_pol_e     pol,
  output logic [MODE_W-1:0] rdata,
  output logic          sel_wr_ev
);
  logic sel_q;

  assign sel_wr_ev = wr && (!bitop || (bitpos == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= 1'b0;
    else if (sel_wr_ev) sel_q <= wdata[0];
  end

  assign pol   = edge_pol_e'(sel_q);
  assign rdata = {{(MODE_W-1){1'b0}}, sel_q};
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det
  import nmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      filt_lvl,
  input  edge_pol_e pol,
  input  logic      resync,
  input  logic      pend,
  output logic      edge_ev,
  output logic      req
);
  logic filt_d;

  // The delayed copy tracks the filtered level; a mode write masks its cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d <= 1'b0;
    else        filt_d <= filt_lvl;
  end

  assign edge_ev = edge_hit(filt_lvl, filt_d, pol);
  assign req     = edge_ev && !pend && !resync;
endmodule

// File: rtl/nmi_pend_ctrl.sv
module nmi_pend_ctrl
  import nmi_pkg::*;
#(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ev,
  input  logic             clr_ev,
  input  logic [REQ_W-1:0] req_in,
  output logic             pend,
  output logic [7:0]       stat_byte,
  output logic [REQ_W-1:0] req_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_ev) pend <= 1'b1;
    else if (clr_ev) pend <= 1'b0;
  end

  always_comb begin
    stat_byte               = '0;
    stat_byte[STAT_PEND_IX] = pend;
  end

  assign req_out = pend ? '0 : req_in;
endmodule

// File: rtl/nmi_edge_ctrl.sv
module nmi_edge_ctrl
  import nmi_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int REQ_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             reg_wr,
  input  logic             reg_bitop,
  input  logic [2:0]       reg_bitpos,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             nmi_return,
  output logic             nmi_req,
  output logic [7:0]       stat_byte,
  input  logic [REQ_W-1:0] req_in,
  output logic [REQ_W-1:0] req_out
);
  logic      filt_lvl;
  logic      mode_wr_ev;
  logic      edge_ev;
  logic      pend;
  edge_pol_e pol;

  nmi_sync_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(2)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .filt_lvl(filt_lvl)
  );

  nmi_mode_reg #(.BW(3)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .bitop(reg_bitop),
    .bitpos(reg_bitpos), .wdata(reg_wdata), .pol(pol),
    .rdata(reg_rdata), .sel_wr_ev(mode_wr_ev)
  );

  nmi_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .filt_lvl(filt_lvl), .pol(pol),
    .resync(mode_wr_ev), .pend(pend), .edge_ev(edge_ev), .req(nmi_req)
  );

  nmi_pend_ctrl #(.REQ_W(REQ_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_ev(nmi_req), .clr_ev(nmi_return),
    .req_in(req_in), .pend(pend), .stat_byte(stat_byte), .req_out(req_out)
  );
endmodule

// File: rtl/nmi_edge_ctrl_chk.sv
module nmi_edge_ctrl_chk #(
  parameter int REQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             nmi_return,
  input logic [7:0]       stat_byte,
  input logic [7:0]       reg_rdata,
  input logic [REQ_W-1:0] req_out,
  input logic             mode_wr_ev,
  input logic             filt_lvl
);
  p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  p_req_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> stat_byte[7]);

  p_no_req_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[7] |-> !nmi_req);

  p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[7] |-> (req_out == '0));

  p_return_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_return && !nmi_req) |=> !stat_byte[7]);

  p_mode_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:1] == 7'd0);

  p_quiet_on_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_ev |-> !nmi_req);

  p_filter_no_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |=> (filt_lvl == $past(filt_lvl)));
endmodule

bind nmi_edge_ctrl nmi_edge_ctrl_chk #(.REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .nmi_return(nmi_return),
  .stat_byte(stat_byte), .reg_rdata(reg_rdata), .req_out(req_out),
  .mode_wr_ev(mode_wr_ev), .filt_lvl(filt_lvl)
);

// File: tb/sim_nmi_edge_ctrl.sv
`timescale 1ns/1ps
module sim_nmi_edge_ctrl;
  localparam int N     = 4;
  localparam int REQ_W = 8;
  localparam int WIN   = 3 * N + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b0;
  logic reg_wr = 1'b0, reg_bitop = 1'b0;
  logic [2:0] reg_bitpos = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic nmi_return = 1'b0;
  logic nmi_req;
  logic [7:0] stat_byte;
  logic [REQ_W-1:0] req_in = 8'hA5;
  logic [REQ_W-1:0] req_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nmi_edge_ctrl #(.FILT_CYC(N), .REQ_W(REQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_wr(reg_wr),
    .reg_bitop(reg_bitop), .reg_bitpos(reg_bitpos), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_return(nmi_return), .nmi_req(nmi_req),
    .stat_byte(stat_byte), .req_in(req_in), .req_out(req_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // Change the pin and return the edge count at which nmi_req is seen (0 = none), plus the pulse count.
  task automatic move_pin(input logic lvl, output int first, output int pulses);
    first = 0; pulses = 0;
    nmi_pin = lvl;
    for (int i = 1; i <= WIN; i++) begin
      step();
      if (nmi_req) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic ret_pulse();
    nmi_return = 1'b1; step(); nmi_return = 1'b0;
  endtask

  task automatic reg_write(input logic bitop, input logic [2:0] pos,
                           input logic [7:0] d, output int reqs);
    reg_wr = 1'b1; reg_bitop = bitop; reg_bitpos = pos; reg_wdata = d;
    reqs = nmi_req ? 1 : 0;
    step();
    reg_wr = 1'b0; reg_bitop = 1'b0;
  endtask

  task automatic t_reset();
    chk(reg_rdata == 8'h00, "R1 mode", reg_rdata, 8'h00);
    chk(stat_byte == 8'h00, "R1 status", stat_byte, 8'h00);
    chk(nmi_req == 1'b0, "R1 req", nmi_req, 0);
    chk(req_out == req_in, "R1/R10 pass-through", req_out, req_in);
  endtask

  task automatic t_fall_default();
    int f, p;
    move_pin(1'b1, f, p);
    chk(p == 0, "R2 rising ignored in falling mode", p, 0);
    nmi_pin = 1'b0; f = 0; p = 0;
    for (int i = 1; i <= WIN; i++) begin
      step();
      if (nmi_req) begin p++; if (f == 0) f = i; end
      if (i == N + 3) begin
        chk(stat_byte == 8'h80, "R8 flag set", stat_byte, 8'h80);
        chk(req_out == '0, "R10 masked", req_out, 0);
      end
    end
    chk(f == N + 2, "R7 latency", f, N + 2);
    chk(p == 1, "R2/R7 single pulse", p, 1);
    ret_pulse();
    chk(stat_byte == 8'h00, "R11 flag cleared", stat_byte, 8'h00);
    chk(req_out == req_in, "R10 unmasked", req_out, req_in);
  endtask

  task automatic t_drop();
    int f, p;
    move_pin(1'b1, f, p);
    move_pin(1'b0, f, p);
    chk(p == 1, "R9 first accepted", p, 1);
    move_pin(1'b1, f, p);
    move_pin(1'b0, f, p);
    chk(p == 0, "R9 nested edge dropped", p, 0);
    ret_pulse();
    p = 0;
    for (int i = 0; i < WIN; i++) begin step(); if (nmi_req) p++; end
    chk(p == 0, "R9 not queued", p, 0);
    chk(stat_byte == 8'h00, "R11 flag stays clear", stat_byte, 0);
  endtask

  task automatic t_rise_mode();
    int f, p, r;
    reg_write(1'b0, 3'd0, 8'hFF, r);
    chk(reg_rdata == 8'h01, "R4 byte write readback", reg_rdata, 8'h01);
    move_pin(1'b1, f, p);
    chk(p == 1 && f == N + 2, "R3 rising accepted", f, N + 2);
    ret_pulse();
    move_pin(1'b0, f, p);
    chk(p == 0, "R3 falling ignored in rising mode", p, 0);
  endtask

  task automatic t_bitop();
    int r;
    reg_write(1'b1, 3'd3, 8'h00, r);
    chk(reg_rdata == 8'h01, "R5 other bit position no effect", reg_rdata, 8'h01);
    reg_write(1'b1, 3'd0, 8'h00, r);
    chk(reg_rdata == 8'h00, "R5 bit 0 cleared", reg_rdata, 8'h00);
    reg_write(1'b1, 3'd0, 8'h01, r);
    chk(reg_rdata == 8'h01, "R5 bit 0 set", reg_rdata, 8'h01);
    reg_write(1'b0, 3'd0, 8'hFE, r);
    chk(reg_rdata == 8'h00, "R4 byte write clears", reg_rdata, 8'h00);
  endtask

  task automatic t_glitch();
    int f, p;
    move_pin(1'b1, f, p);
    nmi_pin = 1'b0;
    for (int i = 0; i < N - 1; i++) step();
    move_pin(1'b1, f, p);
    chk(p == 0, "R6 short low pulse rejected", p, 0);
    move_pin(1'b0, f, p);
    chk(p == 1, "R6 long low pulse accepted", p, 1);
    ret_pulse();
  endtask

  task automatic t_polflip();
    int r, p;
    p = 0;
    reg_write(1'b0, 3'd0, 8'h01, r); p += r;
    for (int i = 0; i < WIN; i++) begin step(); if (nmi_req) p++; end
    reg_write(1'b1, 3'd0, 8'h00, r); p += r;
    for (int i = 0; i < WIN; i++) begin step(); if (nmi_req) p++; end
    chk(p == 0, "R12 polarity change quiet", p, 0);
    chk(stat_byte == 8'h00, "R12 flag unchanged", stat_byte, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_fall_default();
    t_drop();
    t_rise_mode();
    t_bitop();
    t_glitch();
    t_polflip();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule